// File: doc/BRIEF.md
# Rectangle Fill and Monochrome Bitmap Expander

This block is a small drawing engine for an 8-bit-per-pixel linear framebuffer of 1280 by 1024 pixels. Software first loads five configuration registers through a plain write port: an operation code, a drawing color, two packed corner points and a 32-bit monochrome pattern word. It then starts a job by writing to one of two trigger selects. The fill trigger paints every pixel of the rectangle in the color. The expand trigger walks the same rectangle but paints a pixel only where the matching pattern bit is set. Pixels are emitted one at a time on a byte-wide write stream. Each pixel carries a framebuffer byte address and a color byte.

The corners may be given in either order, because the block sorts them. Pixels outside the visible surface are never written. The pixel stream follows valid/ready rules. A pixel is transferred on a rising clock edge where both `pix_valid` and `pix_ready` are high. While `pix_ready` is low, the block holds `pix_valid` high and keeps the address and data unchanged. It never withdraws a pixel it has offered. Back-pressure only stretches a job and never changes its pixel sequence.

Top module: `pixel_blitter`

## Requirements
- R1: After reset, `busy`, `op_err` and `pix_valid` are all 0.
- R2: A write with `cfg_we`=1 selects its target by `cfg_sel` as follows:
  - 0: command. The operation code is taken from bits 31:24.
  - 1: color. The color is taken from bits 7:0.
  - 2 and 3: first and second corner. In each corner, X is in bits 27:16 and Y is in bits 11:0, and all other bits are ignored.
  - 4: pattern word.
  - 5: start a fill.
  - 6: start an expansion.
  - 7: no effect.
  The data written with select 5 or 6 is ignored.
- R3: A fill started while the operation code is 3 emits the rectangle row by row. Y runs from the low to the high corner, and X runs ascending within each row. Both ranges are inclusive. Each pixel has `pix_addr` = 0x38000000 + X + Y*1280 and `pix_data` = color.
- R4: If the second corner's X is below the first corner's X, the two X values are exchanged. The Y values are exchanged in the same way. The result does not depend on which corner is loaded into which register.
- R5: No pixel with X ≥ 1280 or Y ≥ 1024 is emitted. Every other pixel in the rectangle is emitted.
- R6: An expansion reads the pattern most significant bit first, one bit per rectangle position. X advances on every bit. After the high X, the walk returns to the low X and moves to the next Y. A pixel is emitted only where the bit is 1. The expansion ends after the high Y row or after the 32nd bit, whichever comes first. Nothing is emitted after the 32nd bit. The operation code is not used for an expansion.
- R7: If the high X minus the low X is 15 or less, the pattern is shifted left by 16 before an expansion starts. As a result, the expansion uses the low half of the word.
- R8: On a fill trigger accepted while idle, `op_err` is updated as follows:
  - Operation code 1: `op_err` is cleared and no pixel is emitted.
  - Operation code 3: `op_err` is cleared and the fill runs.
  - Any other code: `op_err` is set to 1 and no pixel is emitted.
  `op_err` changes at no other time.
- R9: `busy` rises on the clock edge that accepts a trigger and falls on the edge that transfers the last pixel. Triggers arriving while `busy` is 1 are ignored, including one on that final edge. Configuration writes during a job are stored but affect only later jobs.
- R10: While `pix_valid` is 1 and `pix_ready` is 0, `pix_valid`, `pix_addr` and `pix_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register or trigger select |
| cfg_wdata | input | 32 | Configuration write data |
| pix_ready | input | 1 | Pixel sink can accept |
| pix_valid | output | 1 | Pixel offered |
| pix_addr | output | 32 | Framebuffer byte address of the pixel |
| pix_data | output | 8 | Pixel color byte |
| busy | output | 1 | A job is running |
| op_err | output | 1 | Last fill trigger carried an unknown operation code |

## Verification
Two pairs of functions can coincide in one cycle.

The first pair is the final pixel handshake of a job and a new trigger. With `pix_ready` held high, the bench places a fill trigger exactly on the edge that transfers the last pixel. It expects the trigger to be dropped, `busy` to fall, and no further pixels to appear.

The second pair is a color rewrite and a stray expand trigger landing while pixels are still streaming. The running fill must keep its captured color, and the next fill must use the new color.

Randomised jobs with random back-pressure are compared against a pixel list built by a bench model.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int COORD_W = 12;

  localparam logic [2:0] SEL_CMD       = 3'd0;
  localparam logic [2:0] SEL_COLOR     = 3'd1;
  localparam logic [2:0] SEL_CORNER_A  = 3'd2;
  localparam logic [2:0] SEL_CORNER_B  = 3'd3;
  localparam logic [2:0] SEL_PATTERN   = 3'd4;
  localparam logic [2:0] SEL_GO_FILL   = 3'd5;
  localparam logic [2:0] SEL_GO_EXPAND = 3'd6;

  localparam logic [7:0] OP_SOLID = 8'd3;
  localparam logic [7:0] OP_IDLE  = 8'd1;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } point_t;

  typedef struct packed {
    logic [COORD_W-1:0] x_lo;
    logic [COORD_W-1:0] x_hi;
    logic [COORD_W-1:0] y_lo;
    logic [COORD_W-1:0] y_hi;
  } rect_t;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        busy,
  output logic [7:0]  color,
  output point_t      pt_a,
  output point_t      pt_b,
  output logic [31:0] pattern,
  output logic        go_fill,
  output logic        go_expand,
  output logic        op_err
);
  logic [7:0] opcode;
  logic       fill_req;

  assign fill_req  = cfg_we && (cfg_sel == SEL_GO_FILL) && !busy;
  assign go_fill   = fill_req && (opcode == OP_SOLID);
  assign go_expand = cfg_we && (cfg_sel == SEL_GO_EXPAND) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode  <= '0;
      color   <= '0;
      pt_a    <= '0;
      pt_b    <= '0;
      pattern <= '0;
      op_err  <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_CMD:      opcode  <= cfg_wdata[31:24];
          SEL_COLOR:    color   <= cfg_wdata[7:0];
          SEL_CORNER_A: pt_a    <= '{x: cfg_wdata[27:16], y: cfg_wdata[11:0]};
          SEL_CORNER_B: pt_b    <= '{x: cfg_wdata[27:16], y: cfg_wdata[11:0]};
          SEL_PATTERN:  pattern <= cfg_wdata;
          default: ;
        endcase
      end
      if (fill_req)
        op_err <= !((opcode == OP_SOLID) || (opcode == OP_IDLE));
    end
  end

  // R8: the error flag moves only on an accepted fill trigger
  p_err_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_err != $past(op_err)) |-> $past(cfg_we && (cfg_sel == SEL_GO_FILL) && !busy));
endmodule

// File: rtl/blit_corners.sv
module blit_corners
  import blit_pkg::*;
#(
  parameter int NARROW_SPAN = 15
) (
  input  point_t pt_a,
  input  point_t pt_b,
  output rect_t  rect,
  output logic   narrow
);
  localparam logic [COORD_W-1:0] SPAN_L = COORD_W'(NARROW_SPAN);

  always_comb begin
    if (pt_b.x < pt_a.x) begin
      rect.x_lo = pt_b.x;
      rect.x_hi = pt_a.x;
    end else begin
      rect.x_lo = pt_a.x;
      rect.x_hi = pt_b.x;
    end
    if (pt_b.y < pt_a.y) begin
      rect.y_lo = pt_b.y;
      rect.y_hi = pt_a.y;
    end else begin
      rect.y_lo = pt_a.y;
      rect.y_hi = pt_b.y;
    end
    narrow = (rect.x_hi - rect.x_lo) <= SPAN_L;
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter logic [31:0] FB_BASE  = 32'h3800_0000,
  parameter int          SCR_W    = 1280,
  parameter int          SCR_H    = 1024,
  parameter int          PAT_BITS = 32,
  parameter int          SHIFT_NARROW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                start_expand,
  input  rect_t               rect,
  input  logic                narrow,
  input  logic [7:0]          color,
  input  logic [PAT_BITS-1:0] pattern,
  input  logic                pix_ready,
  output logic                pix_valid,
  output logic [31:0]         pix_addr,
  output logic [7:0]          pix_data,
  output logic                busy
);
  localparam int             CNT_W   = $clog2(PAT_BITS);
  localparam logic [COORD_W:0] W_L   = (COORD_W+1)'(SCR_W);
  localparam logic [COORD_W:0] H_L   = (COORD_W+1)'(SCR_H);
  localparam logic [31:0]    AREA    = 32'(SCR_W * SCR_H);
  localparam logic [31:0]    ROW_INC = 32'(SCR_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PAT_BITS - 1);

  logic                running, expand_mode;
  logic [COORD_W-1:0]  cur_x, cur_y, x_first, x_last, y_last;
  logic [7:0]          ink;
  logic [PAT_BITS-1:0] shreg;
  logic [CNT_W-1:0]    bits_used;
  logic [31:0]         row_base;

  logic on_screen, emit, advance, row_end, col_end, finish;

  always_comb begin
    on_screen = ({1'b0, cur_x} < W_L) && ({1'b0, cur_y} < H_L);
    emit      = running && on_screen && (!expand_mode || shreg[PAT_BITS-1]);
    advance   = running && (!emit || pix_ready);
    if (expand_mode) begin
      row_end = (cur_x == x_last);
      col_end = (cur_y == y_last);
      finish  = (row_end && col_end) || (bits_used == LAST_BIT);
    end else begin
      row_end = (cur_x == x_last) || ({1'b0, cur_x} >= W_L - 1'b1) ||
                ({1'b0, cur_y} >= H_L);
      col_end = (cur_y == y_last) || ({1'b0, cur_y} >= H_L - 1'b1);
      finish  = row_end && col_end;
    end
  end

  assign pix_valid = emit;
  assign pix_addr  = FB_BASE + row_base + {{(32-COORD_W){1'b0}}, cur_x};
  assign pix_data  = ink;
  assign busy      = running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running     <= 1'b0;
      expand_mode <= 1'b0;
      cur_x       <= '0;
      cur_y       <= '0;
      x_first     <= '0;
      x_last      <= '0;
      y_last      <= '0;
      ink         <= '0;
      shreg       <= '0;
      bits_used   <= '0;
      row_base    <= '0;
    end else if (!running) begin
      if (start) begin
        running     <= 1'b1;
        expand_mode <= start_expand;
        cur_x       <= rect.x_lo;
        cur_y       <= rect.y_lo;
        x_first     <= rect.x_lo;
        x_last      <= rect.x_hi;
        y_last      <= rect.y_hi;
        ink         <= color;
        shreg       <= narrow ? (pattern << SHIFT_NARROW) : pattern;
        bits_used   <= '0;
        row_base    <= {{(32-COORD_W){1'b0}}, rect.y_lo} * ROW_INC;
      end
    end else if (advance) begin
      if (expand_mode) begin
        shreg     <= shreg << 1;
        bits_used <= bits_used + 1'b1;
      end
      if (finish) begin
        running <= 1'b0;
      end else if (row_end) begin
        cur_x    <= x_first;
        cur_y    <= cur_y + 1'b1;
        row_base <= row_base + ROW_INC;
      end else begin
        cur_x <= cur_x + 1'b1;
      end
    end
  end

  // R10: an offered pixel is held steady under back-pressure
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_addr) && $stable(pix_data)));

  // R5: every emitted address lies inside the visible surface
  p_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ((pix_addr - FB_BASE) < AREA));

  // R9: no pixel is offered while idle
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pix_valid);

  // R9: a stalled pixel keeps the job alive
  p_busy_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> busy);
endmodule

// File: rtl/pixel_blitter.sv
module pixel_blitter
  import blit_pkg::*;
#(
  parameter logic [31:0] FB_BASE = 32'h3800_0000,
  parameter int          SCR_W   = 1280,
  parameter int          SCR_H   = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        pix_ready,
  output logic        pix_valid,
  output logic [31:0] pix_addr,
  output logic [7:0]  pix_data,
  output logic        busy,
  output logic        op_err
);
  logic [7:0]  color;
  point_t      pt_a, pt_b;
  logic [31:0] pattern;
  logic        go_fill, go_expand;
  rect_t       rect;
  logic        narrow;

  blit_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .color     (color),
    .pt_a      (pt_a),
    .pt_b      (pt_b),
    .pattern   (pattern),
    .go_fill   (go_fill),
    .go_expand (go_expand),
    .op_err    (op_err)
  );

  blit_corners #(.NARROW_SPAN(15)) u_corners (
    .pt_a   (pt_a),
    .pt_b   (pt_b),
    .rect   (rect),
    .narrow (narrow)
  );

  blit_walker #(
    .FB_BASE      (FB_BASE),
    .SCR_W        (SCR_W),
    .SCR_H        (SCR_H),
    .PAT_BITS     (32),
    .SHIFT_NARROW (16)
  ) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (go_fill || go_expand),
    .start_expand (go_expand),
    .rect         (rect),
    .narrow       (narrow),
    .color        (color),
    .pattern      (pattern),
    .pix_ready    (pix_ready),
    .pix_valid    (pix_valid),
    .pix_addr     (pix_addr),
    .pix_data     (pix_data),
    .busy         (busy)
  );
endmodule

// File: tb/pixel_blitter_test.sv
module pixel_blitter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        pix_ready = 1'b0;
  logic        pix_valid;
  logic [31:0] pix_addr;
  logic [7:0]  pix_data;
  logic        busy;
  logic        op_err;

  pixel_blitter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pix_ready(pix_ready), .pix_valid(pix_valid),
    .pix_addr(pix_addr), .pix_data(pix_data), .busy(busy), .op_err(op_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 1;
  int hold_bad = 0;
  int seed_val;
  logic [31:0] got_a[$];
  logic [7:0]  got_d[$];
  logic [31:0] exp_a[$];
  logic [7:0]  exp_d[$];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_a;
  logic [7:0]  prev_d;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // pixel monitor: drive ready, then sample between edges
  always @(negedge clk) begin
    if (prev_stall && !(pix_valid && pix_addr == prev_a && pix_data == prev_d))
      hold_bad++;
    pix_ready = (rdy_mode != 0) ? 1'b1 : (($urandom % 4) != 0);
    #1;
    if (pix_valid && pix_ready) begin
      got_a.push_back(pix_addr);
      got_d.push_back(pix_data);
    end
    prev_stall = pix_valid && !pix_ready;
    prev_a = pix_addr;
    prev_d = pix_data;
  end

  function automatic logic [31:0] pt(input int x, input int y, input logic [7:0] junk);
    return {junk[7:4], x[11:0], junk[3:0], y[11:0]};
  endfunction

  function automatic void model(input bit ex, input logic [31:0] ca, input logic [31:0] cb,
                                input logic [31:0] pat, input logic [7:0] col);
    int x1 = int'(ca[27:16]);
    int y1 = int'(ca[11:0]);
    int x2 = int'(cb[27:16]);
    int y2 = int'(cb[11:0]);
    int t;
    logic [31:0] d;
    if (x2 < x1) begin t = x1; x1 = x2; x2 = t; end
    if (y2 < y1) begin t = y1; y1 = y2; y2 = t; end
    if (ex) begin
      int x = x1;
      int y = y1;
      d = pat;
      if (x2 - x1 <= 15) d = d << 16;
      while (x <= x2 && y <= y2 && d != 0) begin
        if (d[31] && x < 1280 && y < 1024) begin
          exp_a.push_back(32'h3800_0000 + 32'(x) + 32'(y) * 32'd1280);
          exp_d.push_back(col);
        end
        d = d << 1;
        x++;
        if (x > x2) begin x = x1; y++; end
      end
    end else begin
      for (int y = y1; y <= y2; y++)
        for (int x = x1; x <= x2; x++)
          if (x < 1280 && y < 1024) begin
            exp_a.push_back(32'h3800_0000 + 32'(x) + 32'(y) * 32'd1280);
            exp_d.push_back(col);
          end
    end
  endfunction

  task automatic cfg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_lists();
    got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
    hold_bad = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 100000) begin @(negedge clk); n++; end
    chk(n < 100000, req, "job did not finish", n, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req);
    int bad = -1;
    chk(got_a.size() == exp_a.size(), req, "pixel count", got_a.size(), exp_a.size());
    for (int i = 0; i < got_a.size() && i < exp_a.size(); i++)
      if (bad < 0 && (got_a[i] != exp_a[i] || got_d[i] != exp_d[i])) bad = i;
    if (bad >= 0)
      chk(1'b0, req, "pixel addr/data", {got_d[bad], got_a[bad]}, {exp_d[bad], exp_a[bad]});
    else
      chk(1'b1, req, "pixel list", 0, 0);
    chk(hold_bad == 0, "R10", "held pixel changed", hold_bad, 0);
  endtask

  task automatic run_op(input bit ex, input logic [31:0] cmd, input logic [31:0] colr,
                        input logic [31:0] ca, input logic [31:0] cb,
                        input logic [31:0] pat, input string req);
    cfg(3'd0, cmd); cfg(3'd1, colr); cfg(3'd2, ca); cfg(3'd3, cb); cfg(3'd4, pat);
    clear_lists();
    if (ex || cmd[31:24] == 8'd3) model(ex, ca, cb, pat, colr[7:0]);
    cfg(ex ? 3'd6 : 3'd5, $urandom);
    wait_idle(req);
    compare(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_val = $urandom(32'd2024);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && pix_valid == 0 && op_err == 0, "R1", "reset outputs",
        {busy, pix_valid, op_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 plain fill, R2 junk in unused corner bits
    rdy_mode = 1;
    run_op(0, 32'h0300_0000, 32'hABCD_EF5A, pt(10, 20, 8'hF3), pt(13, 22, 8'h5C), 0, "R3");
    // R4 reversed corners
    run_op(0, 32'h0355_5555, 32'h0000_00C3, pt(207, 9, 0), pt(200, 7, 0), 0, "R4");
    // R5 clip at the bottom-right corner
    run_op(0, 32'h0300_0000, 32'h0000_0011, pt(1278, 1022, 0), pt(1281, 1025, 0), 0, "R5");
    // R5 fully off-screen
    run_op(0, 32'h0300_0000, 32'h0000_0011, pt(40, 2000, 0), pt(50, 2003, 0), 0, "R5");

    // R8 opcode handling
    run_op(0, 32'h0700_0000, 32'h22, pt(1, 1, 0), pt(3, 3, 0), 0, "R8");
    chk(op_err == 1, "R8", "unknown op sets error", op_err, 1);
    run_op(1, 32'h0700_0000, 32'h23, pt(4, 4, 0), pt(11, 5, 0), 32'h0000_F00F, "R6");
    chk(op_err == 1, "R8", "expand leaves error", op_err, 1);
    run_op(0, 32'h0100_0000, 32'h24, pt(1, 1, 0), pt(3, 3, 0), 0, "R8");
    chk(op_err == 0, "R8", "op 1 clears error", op_err, 0);
    run_op(0, 32'h0900_0000, 32'h24, pt(1, 1, 0), pt(3, 3, 0), 0, "R8");
    run_op(0, 32'h0300_0000, 32'h25, pt(1, 1, 0), pt(2, 1, 0), 0, "R8");
    chk(op_err == 0, "R8", "op 3 clears error", op_err, 0);

    // R7 narrow rule and R6 wide expansion
    run_op(1, 32'h0, 32'h9E, pt(30, 40, 0), pt(37, 43, 0), 32'h1234_ABCD, "R7");
    run_op(1, 32'h0, 32'h9F, pt(30, 40, 0), pt(49, 41, 0), 32'hF0F0_1234, "R6");
    // R6 rectangle larger than 32 positions
    run_op(1, 32'h0, 32'hA1, pt(60, 70, 0), pt(69, 74, 0), 32'hFFFF_FFFF, "R6");
    // R6 rows below the screen consume bits
    run_op(1, 32'h0, 32'hA2, pt(1276, 1022, 0), pt(1281, 1027, 0), 32'hFFFF_FFFF, "R6");

    // R9 busy: trigger on the final handshake edge, writes during a job
    rdy_mode = 1;
    cfg(3'd0, 32'h0300_0000); cfg(3'd1, 32'h44);
    cfg(3'd2, pt(100, 100, 0)); cfg(3'd3, pt(105, 100, 0));
    clear_lists();
    model(0, pt(100, 100, 0), pt(105, 100, 0), 0, 8'h44);
    cfg(3'd5, 0);
    chk(busy == 1, "R9", "busy after trigger", busy, 1);
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 32'h77;
    @(negedge clk); cfg_sel = 3'd6;
    @(negedge clk); cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1, "R9", "busy before last edge", busy, 1);
    cfg_we = 1'b1; cfg_sel = 3'd5;
    @(negedge clk); cfg_we = 1'b0;
    chk(busy == 0, "R9", "trigger on last edge ignored", busy, 0);
    repeat (5) @(negedge clk);
    compare("R9");
    clear_lists();
    model(0, pt(100, 100, 0), pt(105, 100, 0), 0, 8'h77);
    cfg(3'd5, 0);
    wait_idle("R9");
    compare("R9");

    // R2 select 7 has no effect on the next job
    clear_lists();
    cfg(3'd7, 32'hFFFF_FFFF);
    model(0, pt(100, 100, 0), pt(105, 100, 0), 0, 8'h77);
    cfg(3'd5, 0);
    wait_idle("R2");
    compare("R2");

    // random jobs with back-pressure (R3 R4 R5 R6 R7 R10)
    for (int k = 0; k < 40; k++) begin
      int xb, yb, w, h;
      bit ex;
      logic [31:0] ca, cb;
      rdy_mode = ($urandom % 3 == 0) ? 1 : 0;
      ex = $urandom % 2;
      xb = ($urandom % 2) ? int'($urandom % 1200) : 1266 + int'($urandom % 20);
      yb = ($urandom % 2) ? int'($urandom % 1000) : 1018 + int'($urandom % 10);
      w  = int'($urandom % 20);
      h  = int'($urandom % 6);
      ca = pt(xb, yb, 8'($urandom));
      cb = pt(xb + w, yb + h, 8'($urandom));
      if ($urandom % 2) run_op(ex, 32'h0300_0000, $urandom, cb, ca, $urandom, ex ? "R6" : "R5");
      else              run_op(ex, 32'h0300_0000, $urandom, ca, cb, $urandom, ex ? "R7" : "R3");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule